// File: doc/BRIEF.md
# Converter-Side Serial Output Sequencer

This block is the digital sequencer on the converter side of a three-wire serial read-out. The block is clocked by the serial clock. The active-low chip select marks a frame and acts as an asynchronous reset. While chip select is high the block is shut down, its data pin is released and its power indication is low. When chip select falls, the pin is driven low at once and the block starts tracking the input.

Each falling serial-clock edge advances a saturating edge counter. The first six edges are the track phase, and the two edges after them are the conversion phase. On the eighth falling edge the block captures the parallel result from the converter-core model and puts its MSB on the pin. Each later falling edge shifts out the next bit. After the LSB the pin stays low for any further clocks. Raising chip select at any point ends the frame, clears all state and tri-states the pin, including in the middle of a conversion.

The data pin is modelled as a value plus an output enable, which a pad cell combines into a tri-state driver.

Top module: `conv_serial_seq`

## Requirements
- R1: While cs_n is high, dout_oe and pwr_up are 0. A rising cs_n clears them at once, without waiting for a clock edge.
- R2: When cs_n falls, dout_oe becomes 1, pwr_up becomes 1 and dout is 0, all before any serial-clock edge.
- R3: Up to and including the 7th falling sclk edge of a frame, dout is 0. Together with the level driven at the cs_n fall, this gives eight leading zero bit periods.
- R4: The conversion phase begins after the 6th falling edge. core_result is sampled on the 8th falling edge and is never reloaded in that frame. A value applied after the 6th edge and before the 8th edge is the one captured, and later changes have no effect.
- R5: After falling edge 8+i (i = 0..15), dout equals bit 15-i of the captured word, so the word leaves MSB first.
- R6: From the 24th falling edge on, dout is 0 for every further edge until cs_n rises, and the extra edges change no state.
- R7: A rise of cs_n at any edge count, including during the conversion phase, aborts the frame. The next frame starts from edge 0 and captures a fresh core_result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; state advances on its falling edge |
| cs_n | input | 1 | Active-low frame select; asynchronous reset when high |
| core_result | input | DATA_W | Parallel result from the converter-core model |
| dout | output | 1 | Serial data value, MSB first |
| dout_oe | output | 1 | Pad enable for dout; 0 means high impedance |
| pwr_up | output | 1 | 1 while the block is powered up (frame active) |

## Verification
The reactions to chip select (R1, R2) have no clock latency. The bench checks them 1 ns after it moves cs_n, which is before any serial-clock edge.

Every dout value is due after the falling edge whose number it depends on, with one register on the path. The bench counts falling edges from the cs_n fall and samples dout at the rising edge that follows each falling edge, half a period away from the edge that updates it.

core_result and cs_n are changed only at rising edges, so the value captured on edge 8 is known. The bench's expected bit for edge k is worked out from k and the captured word by its own function.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

  typedef enum logic [2:0] {
    PH_OFF,
    PH_TRACK,
    PH_CONV,
    PH_SHIFT,
    PH_TAIL
  } seq_phase_e;

  // Phase reached after cnt falling edges of the current frame.
  function automatic seq_phase_e phase_of(input logic sel_n, input int cnt,
                                          input int acq, input int lead,
                                          input int frame);
    if (sel_n)           return PH_OFF;
    else if (cnt < acq)  return PH_TRACK;
    else if (cnt < lead) return PH_CONV;
    else if (cnt < frame) return PH_SHIFT;
    else                 return PH_TAIL;
  endfunction

endpackage

// File: rtl/cseq_edge_counter.sv
module cseq_edge_counter #(
  parameter int CNT_W = 5,
  parameter int LIMIT = 24
) (
  input  logic             sclk,
  input  logic             cs_n,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LIMIT);

  // Saturates so that clocks after the frame leave the state alone.
  always_ff @(negedge sclk or posedge cs_n) begin
    if (cs_n)
      cnt <= '0;
    else if (cnt != CNT_MAX)
      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cseq_phase_decode.sv
module cseq_phase_decode
  import conv_seq_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int ACQ   = 6,
  parameter int LEAD  = 8,
  parameter int FRAME = 24
) (
  input  logic             cs_n,
  input  logic [CNT_W-1:0] cnt,
  output logic             latch_pulse,
  output logic             shift_en,
  output logic             pwr_up
);
  localparam logic [CNT_W-1:0] LATCH_AT = CNT_W'(LEAD - 1);

  seq_phase_e ph;

  always_comb begin
    ph          = phase_of(cs_n, int'(cnt), ACQ, LEAD, FRAME);
    latch_pulse = (ph == PH_CONV) && (cnt == LATCH_AT);
    shift_en    = (ph == PH_SHIFT);
    pwr_up      = (ph != PH_OFF);
  end
endmodule

// File: rtl/cseq_shifter.sv
module cseq_shifter #(
  parameter int DATA_W = 16
) (
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              load,
  input  logic              shift,
  input  logic [DATA_W-1:0] din,
  output logic              bit_out
);
  logic [DATA_W-1:0] sr;

  always_ff @(negedge sclk or posedge cs_n) begin
    if (cs_n) begin
      sr      <= '0;
      bit_out <= 1'b0;
    end else if (load) begin
      bit_out <= din[DATA_W-1];
      sr      <= {din[DATA_W-2:0], 1'b0};
    end else if (shift) begin
      bit_out <= sr[DATA_W-1];
      sr      <= {sr[DATA_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/conv_serial_seq.sv
module conv_serial_seq #(
  parameter int DATA_W     = 16,
  parameter int LEAD_ZEROS = 8,
  parameter int ACQ_EDGES  = 6
) (
  input  logic              sclk,
  input  logic              cs_n,
  input  logic [DATA_W-1:0] core_result,
  output logic              dout,
  output logic              dout_oe,
  output logic              pwr_up
);
  localparam int FRAME = LEAD_ZEROS + DATA_W;
  localparam int CNT_W = $clog2(FRAME + 1);

  logic [CNT_W-1:0] edge_cnt;
  logic             latch_pulse;
  logic             shift_en;
  logic             bit_q;

  cseq_edge_counter #(.CNT_W(CNT_W), .LIMIT(FRAME)) u_cnt (
    .sclk(sclk), .cs_n(cs_n), .cnt(edge_cnt)
  );

  cseq_phase_decode #(.CNT_W(CNT_W), .ACQ(ACQ_EDGES), .LEAD(LEAD_ZEROS),
                      .FRAME(FRAME)) u_dec (
    .cs_n(cs_n), .cnt(edge_cnt), .latch_pulse(latch_pulse),
    .shift_en(shift_en), .pwr_up(pwr_up)
  );

  cseq_shifter #(.DATA_W(DATA_W)) u_sh (
    .sclk(sclk), .cs_n(cs_n), .load(latch_pulse), .shift(shift_en),
    .din(core_result), .bit_out(bit_q)
  );

  assign dout    = bit_q;
  assign dout_oe = ~cs_n;
endmodule

// File: rtl/conv_serial_seq_chk.sv
module conv_serial_seq_chk #(
  parameter int DATA_W = 16,
  parameter int LEAD   = 8,
  parameter int CNT_W  = 5
) (
  input logic              sclk,
  input logic              cs_n,
  input logic              dout,
  input logic              dout_oe,
  input logic              pwr_up,
  input logic [DATA_W-1:0] core_result,
  input logic [CNT_W-1:0]  edge_cnt,
  input logic              latch_pulse
);
  localparam logic [CNT_W-1:0] LEAD_C  = CNT_W'(LEAD);
  localparam logic [CNT_W-1:0] FRAME_C = CNT_W'(LEAD + DATA_W);

  always_comb begin
    if (cs_n) begin
      assert_off_R1: assert (!dout_oe && !pwr_up)
        else $error("shutdown outputs active while deselected");
    end
  end

  assert_on_R2: assert property (@(negedge sclk) disable iff (cs_n)
    !cs_n |-> (dout_oe && pwr_up));

  assert_lead_zero_R3: assert property (@(negedge sclk) disable iff (cs_n)
    (edge_cnt < LEAD_C) |-> !dout);

  assert_latch_R4: assert property (@(negedge sclk) disable iff (cs_n)
    latch_pulse |=> (dout == $past(core_result[DATA_W-1])));

  assert_tail_R6: assert property (@(negedge sclk) disable iff (cs_n)
    (edge_cnt == FRAME_C) |=> ($stable(edge_cnt) && !dout));
endmodule

bind conv_serial_seq conv_serial_seq_chk #(
  .DATA_W(DATA_W), .LEAD(LEAD_ZEROS), .CNT_W(CNT_W)
) u_chk (
  .sclk(sclk), .cs_n(cs_n), .dout(dout), .dout_oe(dout_oe),
  .pwr_up(pwr_up), .core_result(core_result), .edge_cnt(edge_cnt),
  .latch_pulse(latch_pulse)
);

// File: tb/conv_serial_seq_test.sv
`timescale 1ns/1ps
module conv_serial_seq_test;
  logic        sclk = 1'b1;
  logic        cs_n = 1'b0;
  logic [15:0] core_result = '0;
  logic        dout, dout_oe, pwr_up;
  int          n_run = 0, n_fail = 0, cycles = 0;
  logic [15:0] got, lat;

  always #2 sclk = ~sclk;

  conv_serial_seq uut (
    .sclk(sclk), .cs_n(cs_n), .core_result(core_result),
    .dout(dout), .dout_oe(dout_oe), .pwr_up(pwr_up)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Bit expected on the pin after falling edge k, given the captured word.
  function automatic logic exp_bit(input int k, input logic [15:0] w);
    if (k >= 8 && k <= 23) return w[23 - k];
    return 1'b0;
  endfunction

  function automatic string tag_of(input int k);
    if (k < 8)  return "R3";
    if (k == 8) return "R4";
    if (k < 24) return "R5";
    return "R6";
  endfunction

  task automatic frame_begin();
    @(posedge sclk);
    cs_n = 1'b0;
    #1;
    check(dout_oe === 1'b1 && pwr_up === 1'b1 && dout === 1'b0, "R2",
          {dout_oe, pwr_up, dout}, 3'b110);
  endtask

  // n falling edges; churn: random core changes; set7: value applied after edge 6
  task automatic frame_edges(input int n, input bit churn, input bit set7,
                             input logic [15:0] v7);
    got = '0;
    for (int k = 1; k <= n; k++) begin
      if (churn) core_result = 16'($urandom);
      if (set7 && k == 7) core_result = v7;
      if (k == 8) lat = core_result;
      @(negedge sclk);
      @(posedge sclk);
      if (k >= 8 && k <= 23) got[23 - k] = dout;
      check(dout === exp_bit(k, lat), tag_of(k), dout, exp_bit(k, lat));
    end
  endtask

  task automatic frame_end(input string req);
    cs_n = 1'b1;
    #1;
    check(dout_oe === 1'b0 && pwr_up === 1'b0, req, {dout_oe, pwr_up}, 0);
    @(posedge sclk);
    @(posedge sclk);
    check(dout_oe === 1'b0 && pwr_up === 1'b0, "R1", {dout_oe, pwr_up}, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed));
    lat = '0;
    #1 cs_n = 1'b1;
    #0.5;
    check(dout_oe === 1'b0 && pwr_up === 1'b0, "R1", {dout_oe, pwr_up}, 0);

    // Directed: all ones, then a sparse pattern with trailing clocks.
    core_result = 16'hffff;
    frame_begin();
    frame_edges(24, 0, 0, '0);
    check(got === 16'hffff, "R5", got, 16'hffff);
    frame_end("R1");

    core_result = 16'h8001;
    frame_begin();
    frame_edges(30, 0, 0, '0);
    check(got === 16'h8001, "R6", got, 16'h8001);
    frame_end("R1");

    // Value applied during the conversion phase is the one captured; later churn ignored.
    core_result = 16'h1234;
    frame_begin();
    frame_edges(24, 0, 1, 16'hbeef);
    check(got === 16'hbeef, "R4", got, 16'hbeef);
    frame_end("R1");
    core_result = 16'h0f0f;
    frame_begin();
    frame_edges(8, 0, 0, '0);
    core_result = 16'hf0f0;
    frame_edges(0, 0, 0, '0);
    for (int k = 9; k <= 24; k++) begin
      core_result = 16'($urandom);
      @(negedge sclk);
      @(posedge sclk);
      check(dout === exp_bit(k, 16'h0f0f), "R4", dout, exp_bit(k, 16'h0f0f));
    end
    frame_end("R1");

    // Abort mid-conversion, then a clean frame with a fresh value.
    core_result = 16'haaaa;
    frame_begin();
    frame_edges(7, 0, 0, '0);
    frame_end("R7");
    core_result = 16'h5a3c;
    frame_begin();
    frame_edges(24, 0, 0, '0);
    check(got === 16'h5a3c, "R7", got, 16'h5a3c);
    frame_end("R1");

    // Abort during shifting.
    core_result = 16'hc3c3;
    frame_begin();
    frame_edges(13, 0, 0, '0);
    frame_end("R7");

    // Random frames of random length with random core churn.
    for (int f = 0; f < 40; f++) begin
      core_result = 16'($urandom);
      frame_begin();
      frame_edges(1 + int'($urandom % 30), 1, 0, '0);
      frame_end("R7");
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  always @(posedge sclk) begin
    cycles++;
    if (cycles > 100000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule